// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a stereo serial audio stream into parallel samples. It is a bus slave: the bit clock, the word clock and the serial data all come from outside. A faster system clock oversamples the three lines and finds the bit-clock edge used for sampling. From that point on, every piece of logic advances once per sampling edge. One shift register collects the incoming bits for all four frame layouts. A small position counter, restarted on each word-clock transition, decides when a left or a right word is complete.

A completed sample is placed at the top of a 32-bit word, so software sees the same scaling at every word length. The left and right samples of a frame appear together on the outputs, with a one-cycle valid pulse. Configuration is static while the stream runs and is applied together with a reset.

Top module: `audio_serial_rx`

## Requirements
- R1: Data is taken MSB first. Word-length code 00/01/10/11 selects 16/20/24/32 bits. Each sample is left-aligned in its 32-bit output, and every bit below the word length reads zero.
- R2: Format code 00 is the I2S layout. The left word is sent while the word clock is low and the right word while it is high. The MSB arrives on the sampling edge one after the word-clock transition, plus the offset.
- R3: Format code 11 is the left-justified layout. The left word is sent while the word clock is high. The MSB arrives on the first sampling edge that sees the new word-clock level, plus the offset.
- R4: Format code 01 is the pulse layout. The first sampling edge that sees the word clock high starts the frame. The left MSB arrives there plus the offset, and the right word follows the left LSB with no gap.
- R5: Format code 10 is the right-justified layout. The left word's LSB is on the last sampling edge before the word clock falls. The right word's LSB is on the last sampling edge before it rises. The offset has no effect in this layout.
- R6: The offset input delays the MSB by that many sampling edges in the I2S, left-justified and pulse layouts.
- R7: With the polarity input at 0, the block samples on rising bit-clock edges. With it at 1, the block samples on falling edges. All four layouts behave the same with either setting.
- R8: Slot bits after a word's LSB are ignored. So are slot bits before its MSB.
- R9: valid_o is high for exactly one system-clock cycle after each right word completes. It stays low after reset until a left word has been captured, so a partial first frame is never reported.
- R10: While reset is held, left_o and right_o are zero and valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt_i | input | 2 | Frame layout: 00 I2S, 01 pulse, 10 right-justified, 11 left-justified |
| cfg_wlen_i | input | 2 | Word length: 00 16, 01 20, 10 24, 11 32 bits |
| cfg_offset_i | input | OFF_W | Extra data delay in bit clocks |
| cfg_bclk_inv_i | input | 1 | Sampling edge: 0 rising, 1 falling |
| bclk_i | input | 1 | Serial bit clock |
| wclk_i | input | 1 | Word clock (frame marker) |
| sdata_i | input | 1 | Serial data |
| left_o | output | SAMPLE_W | Left sample, left-aligned |
| right_o | output | SAMPLE_W | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle pulse when a stereo pair is ready |

## Verification
The position counter is restarted on every word-clock transition. If it drifts or restarts on the wrong transition, the samples shift by whole bits. That error shows in the very next pair as a value scaled by a power of two, or mixed with neighbouring slot bits.

If the wrong sampling edge is used, the same bit-sized shifts appear within one frame. If the captured-left flag goes wrong, valid_o either misses a frame or pulses early. The bench catches this as a mismatch in the number of pairs received after each run of frames.

// File: rtl/asr_pkg.sv
package asr_pkg;
  localparam int SAMPLE_W = 32;

  typedef enum logic [1:0] {
    FMT_I2S = 2'b00,
    FMT_DSP = 2'b01,
    FMT_RJ  = 2'b10,
    FMT_LJ  = 2'b11
  } fmt_e;

  function automatic logic [6:0] wlen_bits(input logic [1:0] code);
    case (code)
      2'b00:   return 7'd16;
      2'b01:   return 7'd20;
      2'b10:   return 7'd24;
      default: return 7'd32;
    endcase
  endfunction
endpackage

// File: rtl/asr_edge_sync.sv
module asr_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_inv_i,
  input  logic bclk_i,
  input  logic wclk_i,
  input  logic sdata_i,
  output logic evt_o,
  output logic wclk_o,
  output logic sdata_o
);
  logic [SYNC_STAGES-1:0] b_s, w_s, d_s;
  logic b_prev, edge_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_s <= '0;
      w_s <= '0;
      d_s <= '0;
      b_prev <= 1'b0;
    end else begin
      b_s <= {b_s[SYNC_STAGES-2:0], bclk_i};
      w_s <= {w_s[SYNC_STAGES-2:0], wclk_i};
      d_s <= {d_s[SYNC_STAGES-2:0], sdata_i};
      b_prev <= b_s[SYNC_STAGES-1];
    end
  end

  // Rising edge when polarity is 0, falling edge when it is 1.
  assign edge_hit = bclk_inv_i ? (b_prev & ~b_s[SYNC_STAGES-1])
                               : (~b_prev & b_s[SYNC_STAGES-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_o <= 1'b0;
      wclk_o <= 1'b0;
      sdata_o <= 1'b0;
    end else begin
      evt_o <= edge_hit;
      wclk_o <= w_s[SYNC_STAGES-1];
      sdata_o <= d_s[SYNC_STAGES-1];
    end
  end

  // Two sampling edges of the same direction need at least two cycles.
  assert_evt_gap_R7: assert property (@(posedge clk) disable iff (rst)
    evt_o |=> !evt_o);
endmodule

// File: rtl/asr_frame_tracker.sv
module asr_frame_tracker import asr_pkg::*; #(
  parameter int OFF_W = 5,
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_i,
  input  logic             wclk_i,
  input  fmt_e             fmt_i,
  input  logic [6:0]       nbits_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic             done_l_o,
  output logic             done_r_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             primed_q, wprev_q, ch_q, act_q;
  logic [POS_W-1:0] pos_q;
  logic             rise, fall, start_l, start_r, ch_now, act_now;
  logic [POS_W-1:0] pos_now, dly, rel, nb;
  logic             in_win, hit_a, hit_b;

  always_comb begin
    rise = evt_i & primed_q & ~wprev_q & wclk_i;
    fall = evt_i & primed_q & wprev_q & ~wclk_i;
    nb   = POS_W'(nbits_i);
    start_l = 1'b0;
    start_r = 1'b0;
    dly = POS_W'(offset_i);
    case (fmt_i)
      FMT_I2S: begin start_l = fall; start_r = rise; dly = POS_W'(offset_i) + POS_W'(1); end
      FMT_LJ:  begin start_l = rise; start_r = fall; end
      FMT_DSP: begin start_l = rise; end
      default: ;
    endcase
    if (start_l || start_r)
      pos_now = '0;
    else if (pos_q == POS_MAX)
      pos_now = POS_MAX;
    else
      pos_now = pos_q + POS_W'(1);
    ch_now  = start_l ? 1'b0 : (start_r ? 1'b1 : ch_q);
    act_now = act_q | start_l | start_r;
    rel    = pos_now - dly;
    in_win = act_now && (pos_now >= dly);
    hit_a  = in_win && (rel == nb - POS_W'(1));
    hit_b  = in_win && (rel == (nb << 1) - POS_W'(1));
    done_l_o = 1'b0;
    done_r_o = 1'b0;
    case (fmt_i)
      FMT_I2S, FMT_LJ: begin
        done_l_o = evt_i & hit_a & ~ch_now;
        done_r_o = evt_i & hit_a & ch_now;
      end
      FMT_DSP: begin
        done_l_o = evt_i & hit_a;
        done_r_o = evt_i & hit_b;
      end
      default: begin
        done_l_o = fall;
        done_r_o = rise;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q <= 1'b0;
      wprev_q <= 1'b0;
      ch_q <= 1'b0;
      act_q <= 1'b0;
      pos_q <= '0;
    end else if (evt_i) begin
      primed_q <= 1'b1;
      wprev_q <= wclk_i;
      ch_q <= ch_now;
      act_q <= act_now;
      pos_q <= pos_now;
    end
  end

  assert_done_on_evt_R9: assert property (@(posedge clk) disable iff (rst)
    (done_l_o || done_r_o) |-> evt_i);
  assert_pos_saturates_R6: assert property (@(posedge clk) disable iff (rst)
    (pos_q == POS_MAX) |=> (pos_q == POS_MAX || pos_q == '0));
endmodule

// File: rtl/asr_shift_core.sv
module asr_shift_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt_i,
  input  logic         sdata_i,
  input  logic [6:0]   nbits_i,
  input  logic         take_prev_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] hist_q, full;
  logic [6:0]   sh;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else if (evt_i) hist_q <= {hist_q[W-2:0], sdata_i};
  end

  // Right-justified words end one edge earlier, so the current bit is left out.
  assign full   = take_prev_i ? hist_q : {hist_q[W-2:0], sdata_i};
  assign sh     = 7'(W) - nbits_i;
  assign word_o = full << sh;
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx import asr_pkg::*; #(
  parameter int OFF_W       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          cfg_fmt_i,
  input  logic [1:0]          cfg_wlen_i,
  input  logic [OFF_W-1:0]    cfg_offset_i,
  input  logic                cfg_bclk_inv_i,
  input  logic                bclk_i,
  input  logic                wclk_i,
  input  logic                sdata_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam int POS_W = $clog2((1 << OFF_W) + 2 * SAMPLE_W + 2);

  fmt_e                fmt;
  logic [6:0]          nbits;
  logic                evt, w_s, d_s, done_l, done_r, seen_q;
  logic [SAMPLE_W-1:0] word, left_hold, low_mask;

  assign fmt      = fmt_e'(cfg_fmt_i);
  assign nbits    = wlen_bits(cfg_wlen_i);
  assign low_mask = (nbits == 7'd32) ? '0 : ({SAMPLE_W{1'b1}} >> nbits);

  asr_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk_inv_i(cfg_bclk_inv_i),
    .bclk_i(bclk_i), .wclk_i(wclk_i), .sdata_i(sdata_i),
    .evt_o(evt), .wclk_o(w_s), .sdata_o(d_s));

  asr_frame_tracker #(.OFF_W(OFF_W), .POS_W(POS_W)) u_track (
    .clk(clk), .rst(rst), .evt_i(evt), .wclk_i(w_s), .fmt_i(fmt),
    .nbits_i(nbits), .offset_i(cfg_offset_i),
    .done_l_o(done_l), .done_r_o(done_r));

  asr_shift_core #(.W(SAMPLE_W)) u_shift (
    .clk(clk), .rst(rst), .evt_i(evt), .sdata_i(d_s), .nbits_i(nbits),
    .take_prev_i(fmt == FMT_RJ), .word_o(word));

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold <= '0;
      seen_q <= 1'b0;
      left_o <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done_l) begin
        left_hold <= word;
        seen_q <= 1'b1;
      end
      if (done_r) begin
        left_o <= left_hold;
        right_o <= word;
        valid_o <= seen_q;
      end
    end
  end

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  assert_valid_after_left_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_o) |-> seen_q);
  assert_low_bits_zero_R1: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (((left_o | right_o) & low_mask) == '0));
  assert_reset_clear_R10: assert property (@(posedge clk)
    $past(rst) |-> (!valid_o && left_o == '0 && right_o == '0));
endmodule

// File: tb/audio_serial_rx_test.sv
module audio_serial_rx_test;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cfg_fmt = 2'b00, cfg_wlen = 2'b00;
  logic [4:0] cfg_off = '0;
  logic cfg_inv = 1'b0;
  logic bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic [31:0] left_o, right_o;
  logic valid_o;

  int n_tests = 0;
  int n_fail = 0;
  logic [31:0] rx_l[$], rx_r[$], ex_l[$], ex_r[$];

  always #2 clk = ~clk;

  audio_serial_rx uut (
    .clk(clk), .rst(rst), .cfg_fmt_i(cfg_fmt), .cfg_wlen_i(cfg_wlen),
    .cfg_offset_i(cfg_off), .cfg_bclk_inv_i(cfg_inv), .bclk_i(bclk),
    .wclk_i(wclk), .sdata_i(sdata), .left_o(left_o), .right_o(right_o),
    .valid_o(valid_o));

  always @(negedge clk) if (!rst && valid_o) begin
    rx_l.push_back(left_o);
    rx_r.push_back(right_o);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int nbits_of(input logic [1:0] c);
    return (c == 2'b00) ? 16 : (c == 2'b01) ? 20 : (c == 2'b10) ? 24 : 32;
  endfunction

  function automatic logic [31:0] expect_word(input logic [31:0] v, input int n);
    logic [31:0] m;
    m = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    return (v & m) << (32 - n);
  endfunction

  // One sampling edge: data and word clock change in the inactive phase.
  task automatic ev(input logic w, input logic d);
    @(posedge clk);
    bclk <= cfg_inv;
    wclk <= w;
    sdata <= d;
    repeat (HALF - 1) @(posedge clk);
    @(posedge clk);
    bclk <= ~cfg_inv;
    repeat (HALF - 1) @(posedge clk);
  endtask

  task automatic send_frame(input int s, input logic [31:0] lv, input logic [31:0] rv);
    int n, off, d0;
    n = nbits_of(cfg_wlen);
    off = int'(cfg_off);
    d0 = (cfg_fmt == 2'b00) ? off + 1 : off;
    for (int j = 0; j < 2 * s; j++) begin
      logic w, b;
      int half, k, i;
      b = 1'($urandom);
      half = (j >= s) ? 1 : 0;
      k = j - half * s;
      case (cfg_fmt)
        2'b01: begin
          w = (j == 0);
          i = j - off;
          if (i >= 0 && i < n) b = lv[n - 1 - i];
          else if (i >= n && i < 2 * n) b = rv[2 * n - 1 - i];
        end
        2'b10: begin
          w = (half == 0);
          i = k - (s - n);
          if (i >= 0) b = half ? rv[n - 1 - i] : lv[n - 1 - i];
        end
        default: begin
          w = (cfg_fmt == 2'b00) ? (half == 1) : (half == 0);
          i = k - d0;
          if (i >= 0 && i < n) b = half ? rv[n - 1 - i] : lv[n - 1 - i];
        end
      endcase
      ev(w, b);
    end
  endtask

  task automatic run_batch(input string req, input logic [1:0] fmt,
                           input logic [1:0] wl, input int off, input logic inv,
                           input int extra, input int frames, input bit partial);
    int n, s;
    logic idle_w, tail_w;
    cfg_fmt = fmt;
    cfg_wlen = wl;
    cfg_off = 5'(off);
    cfg_inv = inv;
    bclk = inv;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!valid_o && left_o == 0 && right_o == 0, "R10", "reset state",
          {31'd0, valid_o} | left_o | right_o, 32'd0);
    @(posedge clk);
    rst <= 1'b0;
    repeat (2) @(posedge clk);
    rx_l.delete(); rx_r.delete(); ex_l.delete(); ex_r.delete();
    n = nbits_of(wl);
    s = n + off + 1 + extra;
    idle_w = (fmt == 2'b00);
    tail_w = (fmt == 2'b10) ? 1'b1 : idle_w;
    if (partial) begin
      ev(1'b0, 1'b1); ev(1'b0, 1'b0);
      for (int j = 0; j < s; j++) ev(1'b1, 1'($urandom));
    end else begin
      ev(idle_w, 1'($urandom)); ev(idle_w, 1'($urandom));
    end
    for (int f = 0; f < frames; f++) begin
      logic [31:0] lv, rv;
      lv = $urandom;
      rv = $urandom;
      ex_l.push_back(expect_word(lv, n));
      ex_r.push_back(expect_word(rv, n));
      send_frame(s, lv, rv);
    end
    ev(tail_w, 1'b0); ev(tail_w, 1'b0);
    repeat (10) @(posedge clk);
    check(rx_l.size() == ex_l.size(), req, "pair count",
          32'(rx_l.size()), 32'(ex_l.size()));
    for (int f = 0; f < ex_l.size() && f < rx_l.size(); f++) begin
      check(rx_l[f] == ex_l[f], req, "left sample", rx_l[f], ex_l[f]);
      check(rx_r[f] == ex_r[f], req, "right sample", rx_r[f], ex_r[f]);
    end
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_A11D));
    // R2 / R1: I2S at every word length
    run_batch("R2", 2'b00, 2'b00, 0, 1'b0, 0, 3, 1'b0);
    run_batch("R1", 2'b00, 2'b01, 0, 1'b0, 2, 2, 1'b0);
    run_batch("R1", 2'b00, 2'b10, 0, 1'b0, 1, 2, 1'b0);
    run_batch("R1", 2'b00, 2'b11, 0, 1'b0, 0, 2, 1'b0);
    // R3: left-justified, no offset and with offset
    run_batch("R3", 2'b11, 2'b10, 0, 1'b0, 3, 3, 1'b0);
    run_batch("R6", 2'b11, 2'b00, 6, 1'b0, 0, 2, 1'b0);
    // R4: pulse layout, right word packed behind left
    run_batch("R4", 2'b01, 2'b00, 0, 1'b0, 0, 3, 1'b0);
    run_batch("R6", 2'b01, 2'b11, 3, 1'b0, 2, 2, 1'b0);
    // R5: right-justified, offset must not matter
    run_batch("R5", 2'b10, 2'b01, 0, 1'b0, 4, 3, 1'b0);
    run_batch("R5", 2'b10, 2'b00, 7, 1'b0, 0, 3, 1'b0);
    // R7: falling-edge sampling
    run_batch("R7", 2'b00, 2'b00, 2, 1'b1, 1, 2, 1'b0);
    run_batch("R7", 2'b10, 2'b10, 0, 1'b1, 2, 2, 1'b0);
    // R8: long slots with random fill around the word
    run_batch("R8", 2'b00, 2'b00, 1, 1'b0, 14, 2, 1'b0);
    // R9: a lone right half after reset yields no pair
    run_batch("R9", 2'b00, 2'b00, 0, 1'b0, 2, 2, 1'b1);
    for (int t = 0; t < 18; t++) begin
      logic [1:0] f, w;
      f = 2'($urandom);
      w = 2'($urandom);
      run_batch("R1", f, w, int'($urandom % 8), 1'($urandom),
                int'($urandom % 4), 3, 1'b0);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule